// File: doc/BRIEF.md
# NAND Bank Select and Strobe Decoder

This block connects a simple valid/ready CPU bus to as many as four external NAND banks. A control register carries two bits per bank, an enable and a chip-assert. A bank's active-low chip enable goes low only while both of its bits are set. Writing zero to the register releases and disables every bank at once. A second register returns the synchronized ready/busy line.

Byte accesses into a bank's address window become NAND bus cycles. Two offset bits of the window address choose the kind of cycle: command (CLE high), address (ALE high) or plain data. A write cycle drives the byte with fixed setup, strobe and hold widths around a low pulse on the write strobe. A read cycle pulses the read strobe and returns the byte sampled on its last low clock. An access that would raise CLE and ALE together is refused with an error. An access to a disabled bank finishes at once and makes no strobe.

Address map: when `bus_addr[19]` is 1 the access goes to the registers, with `bus_addr[2]` = 0 for control and 1 for status. When it is 0 the access goes to bank `bus_addr[18:17]`, and window bits 16 (ALE) and 15 (CLE) choose the cycle kind.

Top module: `nand_bank_ctrl`

## Requirements
- R1: The control register sits at `bus_addr[19]`=1, `bus_addr[2]`=0. Bank n's enable is bit 2n and its assert is bit 2n+1. Bits 7:0 are stored, and bits 31:8 read back as zero.
- R2: `nand_ce_n[n]` is low exactly when bank n has both its enable and its assert bit set. Writing 0 to the control register drives all chip enables high.
- R3: In a bank window, bit 15 set alone gives a command cycle (CLE=1, ALE=0). Bit 16 set alone gives an address cycle (ALE=1, CLE=0). Neither bit set gives a data cycle (both low).
- R4: A bank access with bits 15 and 16 both set makes no strobe and completes with `bus_err`=1.
- R5: On a bank write, CLE, ALE and the data byte are valid and `nand_dq_oe` is high for 2 clocks before `nand_we_n` falls. `nand_we_n` then stays low for 3 clocks, and the same signals stay unchanged for 1 clock after it rises.
- R6: On a bank read, `nand_re_n` is low for exactly 3 clocks. The byte on `nand_dq_in` at the end of the third low clock is returned in `bus_rdata[7:0]`, with the upper bits zero.
- R7: An access to a bank whose enable bit is 0 makes no strobe and completes one clock after acceptance. A read returns 0x000000FF.
- R8: `bus_ready` is a single-cycle pulse that ends each accepted access. A bank cycle raises it 7 clocks after the request is driven, and a register access raises it 1 clock after.
- R9: Only `bus_wdata[7:0]` reaches the NAND data bus.
- R10: `nand_rb` passes through two flip-flops, and status bit 0 returns the synchronized value.
- R11: CLE and ALE are never high together, and `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_valid | input | 1 | Request valid, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Request address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_err | output | 1 | Illegal access, valid with `bus_ready` |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 4 | Per-bank chip enable, active low |
| nand_dq_out | output | 8 | Data driven to the NAND bus |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Data from the NAND bus |
| nand_rb | input | 1 | Ready/busy from the devices |

## Verification
The hardest point to observe is the read capture point. If the byte were sampled on the first or second low clock of `nand_re_n`, a device that holds its data steady would not show it. The bench's device model therefore changes `nand_dq_in` on every low clock of the read strobe, so that each possible sampling clock returns a different byte, and only a capture on the third low clock gives the expected value. Strobe widths are measured at the pins by counting the clocks around each fall and rise of the write strobe. Every write strobe is checked against a queue of expected CLE/ALE/chip-enable/data tuples, so a strobe that should not occur is caught as well.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  // Window layout shared by decoder and top
  localparam int CMD_BIT = 15;
  localparam int ALE_BIT = 16;
  localparam int WIN_W   = 17;
  localparam int BUS_W   = 32;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    CYC_DATA = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    TOP_IDLE = 2'd0,
    TOP_WAIT = 2'd1,
    TOP_RESP = 2'd2
  } top_state_e;

  typedef enum logic [1:0] {
    STB_IDLE  = 2'd0,
    STB_SETUP = 2'd1,
    STB_PULSE = 2'd2,
    STB_HOLD  = 2'd3
  } stb_state_e;
endpackage

// File: rtl/nbc_addr_decode.sv
module nbc_addr_decode
  import nbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BANK_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_reg,
  output logic              sel_status,
  output logic [BANK_W-1:0] bank_idx,
  output cyc_kind_e         kind,
  output logic              illegal
);
  always_comb begin
    is_reg     = addr[ADDR_W-1];
    sel_status = addr[2];
    bank_idx   = addr[WIN_W +: BANK_W];
    illegal    = !addr[ADDR_W-1] && addr[CMD_BIT] && addr[ALE_BIT];
    if (addr[ALE_BIT])      kind = CYC_ADDR;
    else if (addr[CMD_BIT]) kind = CYC_CMD;
    else                    kind = CYC_DATA;
  end
endmodule

// File: rtl/nbc_sync.sv
module nbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nbc_strobe_timer.sv
module nbc_strobe_timer
  import nbc_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 3,
  parameter int HOLD_CLKS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_read,
  output logic active,
  output logic we_n,
  output logic re_n,
  output logic capture,
  output logic done
);
  localparam int MAX_A  = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
  localparam int MAX_C  = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  stb_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              read_q, read_d;
  logic              last;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_W'(1);
    read_d  = read_q;
    last    = 1'b0;
    capture = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      STB_IDLE: begin
        cnt_d = '0;
        if (start) begin
          state_d = STB_SETUP;
          read_d  = is_read;
        end
      end
      STB_SETUP: begin
        last = (cnt_q == CNT_W'(SETUP_CLKS - 1));
        if (last) begin state_d = STB_PULSE; cnt_d = '0; end
      end
      STB_PULSE: begin
        last    = (cnt_q == CNT_W'(PULSE_CLKS - 1));
        capture = last && read_q;
        if (last) begin state_d = STB_HOLD; cnt_d = '0; end
      end
      STB_HOLD: begin
        last = (cnt_q == CNT_W'(HOLD_CLKS - 1));
        done = last;
        if (last) begin state_d = STB_IDLE; cnt_d = '0; end
      end
      default: state_d = STB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STB_IDLE;
      cnt_q   <= '0;
      read_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      read_q  <= read_d;
    end
  end

  assign active = (state_q != STB_IDLE);
  assign we_n   = !((state_q == STB_PULSE) && !read_q);
  assign re_n   = !((state_q == STB_PULSE) && read_q);
endmodule

// File: rtl/nand_bank_ctrl.sv
module nand_bank_ctrl
  import nbc_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 20,
  parameter int SETUP_CLKS  = 2,
  parameter int PULSE_CLKS  = 3,
  parameter int HOLD_CLKS   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_ready,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic                 nand_cle,
  output logic                 nand_ale,
  output logic                 nand_we_n,
  output logic                 nand_re_n,
  output logic [NUM_BANKS-1:0] nand_ce_n,
  output logic [7:0]           nand_dq_out,
  output logic                 nand_dq_oe,
  input  logic [7:0]           nand_dq_in,
  input  logic                 nand_rb
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CTRL_W = 2 * NUM_BANKS;

  logic [CTRL_W-1:0]    ctrl_q;
  logic [NUM_BANKS-1:0] en_vec, as_vec;
  top_state_e           state_q, state_d;
  cyc_kind_e            kind_q, dec_kind;
  logic                 write_q;
  logic [BYTE_W-1:0]    dout_q;
  logic [BUS_W-1:0]     rdata_q, rdata_d;
  logic                 err_q, err_d;

  logic                 dec_is_reg, dec_status, dec_illegal;
  logic [BANK_W-1:0]    dec_bank;
  logic                 accept, ctrl_we, start_stb, rdata_en;
  logic                 stb_active, stb_we_n, stb_re_n, stb_capture, stb_done;
  logic                 rb_sync;

  nbc_addr_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_decode (
    .addr(bus_addr), .is_reg(dec_is_reg), .sel_status(dec_status),
    .bank_idx(dec_bank), .kind(dec_kind), .illegal(dec_illegal)
  );

  nbc_strobe_timer #(
    .SETUP_CLKS(SETUP_CLKS), .PULSE_CLKS(PULSE_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start_stb), .is_read(!bus_write),
    .active(stb_active), .we_n(stb_we_n), .re_n(stb_re_n),
    .capture(stb_capture), .done(stb_done)
  );

  nbc_sync #(.STAGES(SYNC_STAGES)) i_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign en_vec[b]    = ctrl_q[2*b];
    assign as_vec[b]    = ctrl_q[2*b+1];
    assign nand_ce_n[b] = !(en_vec[b] && as_vec[b]);
  end

  always_comb begin
    accept    = bus_valid && (state_q == TOP_IDLE);
    ctrl_we   = accept && dec_is_reg && bus_write && !dec_status;
    start_stb = accept && !dec_is_reg && !dec_illegal && en_vec[dec_bank];
    state_d   = state_q;
    rdata_d   = rdata_q;
    err_d     = err_q;
    rdata_en  = 1'b0;
    unique case (state_q)
      TOP_IDLE: if (accept) begin
        rdata_en = 1'b1;
        err_d    = 1'b0;
        rdata_d  = '0;
        state_d  = start_stb ? TOP_WAIT : TOP_RESP;
        if (dec_is_reg) begin
          if (!bus_write)
            rdata_d = dec_status ? BUS_W'(rb_sync) : BUS_W'(ctrl_q);
        end else if (dec_illegal) begin
          err_d = 1'b1;
        end else if (!en_vec[dec_bank] && !bus_write) begin
          rdata_d = BUS_W'(8'hFF);
        end
      end
      TOP_WAIT: begin
        if (stb_capture) begin
          rdata_en = 1'b1;
          rdata_d  = BUS_W'(nand_dq_in);
        end
        if (stb_done) state_d = TOP_RESP;
      end
      TOP_RESP: state_d = TOP_IDLE;
      default:  state_d = TOP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TOP_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CYC_DATA;
      write_q <= 1'b0;
      dout_q  <= '0;
    end else if (accept) begin
      kind_q  <= dec_kind;
      write_q <= bus_write;
      dout_q  <= bus_wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_ready   = (state_q == TOP_RESP);
  assign bus_rdata   = rdata_q;
  assign bus_err     = err_q && bus_ready;
  assign nand_cle    = stb_active && (kind_q == CYC_CMD);
  assign nand_ale    = stb_active && (kind_q == CYC_ADDR);
  assign nand_we_n   = stb_we_n;
  assign nand_re_n   = stb_re_n;
  assign nand_dq_out = dout_q;
  assign nand_dq_oe  = stb_active && write_q;
endmodule

// File: rtl/nbc_chk.sv
module nbc_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_ready,
  input logic bus_err,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe,
  input logic [7:0] nand_dq_out,
  input logic nand_rb,
  input logic rb_sync
);
  logic [1:0] since_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  // R11
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R5
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> $stable(nand_cle) && $stable(nand_ale)
                         && $stable(nand_dq_out) && nand_dq_oe);

  // R5
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> $stable(nand_cle) && $stable(nand_ale)
                         && $stable(nand_dq_out) && nand_dq_oe);

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  // R4
  err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ready);

  // R10
  rb_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q >= 2'd2) |-> (rb_sync == $past(nand_rb, 2)));
endmodule

bind nand_bank_ctrl nbc_chk i_nbc_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_err(bus_err),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe), .nand_dq_out(nand_dq_out),
  .nand_rb(nand_rb), .rb_sync(rb_sync)
);

// File: tb/test_nand_bank_ctrl.sv
module test_nand_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_err;
  logic [31:0] bus_rdata;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [3:0]  nand_ce_n;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = 8'h40;
  logic        nand_rb = 1'b1;

  int total = 0, bad = 0;
  bit finished = 0;

  // measured by the driver during the last bus operation
  int cyc, pre_n, low_n, post_n, rlow_n;
  logic [31:0] rd;
  logic        er;

  logic [13:0] exp_q[$];
  logic [13:0] last_ev;
  logic        prev_we_low = 1'b0;
  int          re_cnt = 0;

  localparam logic [19:0] CTRL_A = 20'h80000;
  localparam logic [19:0] STAT_A = 20'h80004;

  always #4 clk = ~clk;

  nand_bank_ctrl i_nand_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model: data changes on every low clock of the read strobe
  always @(negedge clk) begin
    if (!nand_re_n) re_cnt = re_cnt + 1;
    else            re_cnt = 0;
    nand_dq_in = 8'h40 + 8'(re_cnt);
  end

  // monitor: pops expected strobe tuples on every write strobe rise
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n) last_ev = {nand_cle, nand_ale, nand_ce_n, nand_dq_out};
      if (nand_we_n && prev_we_low) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected strobe", 32'(last_ev), 32'h0);
        end else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          chk(last_ev == e, "R3/R9 strobe tuple", 32'(last_ev), 32'(e));
        end
      end
      prev_we_low = !nand_we_n;
    end
  end

  task automatic bus_op(input logic wr, input logic [19:0] a, input logic [31:0] d);
    bit seen_low;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    cyc = 0; pre_n = 0; low_n = 0; post_n = 0; rlow_n = 0; seen_low = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (!nand_we_n) begin low_n++; seen_low = 1; end
      else if (nand_dq_oe && !seen_low) pre_n++;
      else if (nand_dq_oe && seen_low) post_n++;
      if (!nand_re_n) rlow_n++;
    end while (!bus_ready && cyc < 50);
    rd = bus_rdata; er = bus_err;
    bus_valid = 1'b0;
  endtask

  task automatic bank_write(input logic [19:0] a, input logic [7:0] byt,
                            input logic c, input logic l, input string req);
    exp_q.push_back({c, l, nand_ce_n, byt});
    bus_op(1'b1, a, {24'hABCDEF, byt});
    chk(pre_n == 2, {req, " R5 setup"}, 32'(pre_n), 2);
    chk(low_n == 3, {req, " R5 strobe"}, 32'(low_n), 3);
    chk(post_n == 1, {req, " R5 hold"}, 32'(post_n), 1);
    chk(cyc == 7, {req, " R8 latency"}, 32'(cyc), 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: R2 R8
    chk(nand_ce_n == 4'hF, "R2 reset ce_n", 32'(nand_ce_n), 32'hF);
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !bus_ready,
        "R8 reset outputs", 32'({nand_we_n, nand_re_n, nand_cle, nand_ale, bus_ready}), 32'b11000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 readback, R2 pairing
    bus_op(1'b1, CTRL_A, 32'h0000_0003);
    chk(cyc == 1, "R8 register latency", 32'(cyc), 1);
    chk(nand_ce_n == 4'b1110, "R2 bank0 only", 32'(nand_ce_n), 32'hE);
    bus_op(1'b1, CTRL_A, 32'hFFFF_FF9F);
    chk(nand_ce_n == 4'b1100, "R2 needs both bits", 32'(nand_ce_n), 32'hC);
    bus_op(1'b0, CTRL_A, 32'h0);
    chk(rd == 32'h0000_009F, "R1 readback", rd, 32'h9F);
    bus_op(1'b1, CTRL_A, 32'h0);
    chk(nand_ce_n == 4'hF, "R2 zero releases all", 32'(nand_ce_n), 32'hF);
    bus_op(1'b0, CTRL_A, 32'h0);
    chk(rd == 32'h0, "R1 zero readback", rd, 32'h0);

    // cycle kinds R3 R5 R9
    bus_op(1'b1, CTRL_A, 32'h0000_00FF);
    bank_write(20'h28000, 8'h70, 1'b1, 1'b0, "R3 command");
    bank_write(20'h50000, 8'hA5, 1'b0, 1'b1, "R3 address");
    bank_write(20'h60123, 8'h3C, 1'b0, 1'b0, "R3 data");

    // read capture on last low clock R6
    bus_op(1'b0, 20'h00010, 32'h0);
    chk(rd == 32'h0000_0043, "R6 capture third low clock", rd, 32'h43);
    chk(rlow_n == 3, "R6 read strobe width", 32'(rlow_n), 3);
    chk(low_n == 0, "R6 no write strobe", 32'(low_n), 0);

    // illegal R4
    bus_op(1'b1, 20'h18000, 32'h11);
    chk(er == 1'b1, "R4 error flag", 32'(er), 1);
    chk(low_n == 0 && rlow_n == 0, "R4 no strobes", 32'(low_n + rlow_n), 0);

    // disabled bank R7
    bus_op(1'b1, CTRL_A, 32'h0000_00FC);
    bus_op(1'b0, 20'h00020, 32'h0);
    chk(rd == 32'h0000_00FF, "R7 read value", rd, 32'hFF);
    chk(cyc == 1 && rlow_n == 0, "R7 immediate no strobe", 32'(cyc), 1);
    bus_op(1'b1, 20'h08000, 32'h55);
    chk(low_n == 0 && er == 1'b0, "R7 write no strobe", 32'(low_n), 0);

    // ready/busy R10
    @(negedge clk); nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    bus_op(1'b0, STAT_A, 32'h0);
    chk(rd == 32'h0, "R10 busy", rd, 32'h0);
    nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    bus_op(1'b0, STAT_A, 32'h0);
    chk(rd == 32'h1, "R10 ready", rd, 32'h1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all strobes seen", 32'(exp_q.size()), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule